// File: doc/BRIEF.md
# Monitor Channel Receive Handler

This block is the receive half of a frame-oriented monitor channel. On every frame strobe it samples a handshake bit coming from the sender (`mx_in`) and the byte carried in that frame. A falling edge of `mx_in` across two frames marks a new byte. Two mode bits decide which bytes are kept for the host. With `rx_irq_en` low, nothing is kept. With only `rx_irq_en` set, only the opening byte of each packet is kept. With both `rx_irq_en` and `mr_ctrl_en` set, every byte is kept and the block drives the acknowledge bit `mr_out` following the channel protocol.

A kept byte goes to the host over a valid/ready stream (`rx_data`, `rx_valid`, `rx_ready`). A high `rx_valid` is the data-ready status. Three sticky event flags record the events the block detects: end of reception, acknowledge sent, and a byte dropped because the host had not yet read the previous one. One enable covers all three flags. `irq` combines the data-ready status with the enabled event flags.

Top module: `mon_rx_handler`

## Requirements
- R1: After reset, `rx_valid` is 0, `mr_out` is 1, all three event flags are 0, and `irq` is 0.
- R2: A new byte is one whose frame strobe sees `mx_in`=0 when the previous strobed frame saw `mx_in`=1. When such a byte is kept, `rx_data` shows that frame's byte from the clock after the strobe.
- R3: With `rx_irq_en`=0, no byte is kept and `rx_valid` stays 0, including for the opening byte of a packet.
- R4: With `rx_irq_en`=1 and `mr_ctrl_en`=0, only the opening byte of a packet is kept. Later bytes of the same packet leave `rx_valid` at 0.
- R5: With both enables at 1, every new byte is kept and sets `rx_valid`.
- R6: A kept byte holds `rx_data` and `rx_valid` until the host raises `rx_ready` for a cycle. If a new byte arrives while the slot is still full, the new byte is dropped, the held byte is kept, and `sts_abort` is set.
- R7: `mr_out` is 1 except in full mode after the host takes a byte. It then goes to 0 on the clock that accepts the byte and returns to 1 at the next frame strobe with `mx_in`=1.
- R8: In full mode, `sts_ack` is set on the clock on which the host takes a byte.
- R9: After a packet has started, two strobed frames in a row with `mx_in`=1 set `sts_end` and close the packet. A single frame with `mx_in`=1 between bytes does not set it.
- R10: If `mr_ctrl_en` falls while a packet is open, the packet is dropped without setting `sts_end`. The next new byte then counts as the opening byte of a new packet.
- R11: The event flags are sticky and are cleared by `stat_clr`. A flag set on the same clock as the clear stays set.
- R12: `irq` is `rx_valid` OR (`evt_irq_en` AND any event flag).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle strobe per frame; `mx_in` and `mon_byte` are valid with it |
| mx_in | input | 1 | Sender handshake bit for the current frame |
| mon_byte | input | 8 | Monitor byte of the current frame |
| rx_irq_en | input | 1 | Receive data-ready enable |
| mr_ctrl_en | input | 1 | Per-byte storage and acknowledge control |
| evt_irq_en | input | 1 | Common enable for the three event flags |
| rx_ready | input | 1 | Host takes the held byte |
| stat_clr | input | 1 | Host clears the event flags |
| rx_data | output | 8 | Held received byte |
| rx_valid | output | 1 | Held byte present (data-ready status) |
| mr_out | output | 1 | Acknowledge bit returned to the sender |
| sts_end | output | 1 | End-of-reception flag |
| sts_ack | output | 1 | Acknowledge-sent flag |
| sts_abort | output | 1 | Dropped-byte flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sweeps all three modes against packets of one to three bytes, with the event enable alternating between runs. A design that used the wrong mode decode would keep bytes it should skip, or flag later bytes in first-byte mode. A design that took one `mx_in`=1 frame as the end would set `sts_end` at the gap between bytes. The bench also sends a second byte while the first is still unread; a design that overwrote the slot would lose the held byte. It drops `mr_ctrl_en` in the middle of a packet; a design that kept tracking the packet would report an end it must not report, or skip the next opening byte. Finally, it clears the flags on the same clock that an end is detected; a design that let the clear win would lose the flag.

// File: rtl/mon_rx_pkg.sv
package mon_rx_pkg;
  typedef enum logic [1:0] {
    RX_OFF   = 2'd0,
    RX_FIRST = 2'd1,
    RX_ALL   = 2'd2
  } rx_mode_e;

  localparam int unsigned EVT_N   = 3;
  localparam int unsigned EVT_END = 0;
  localparam int unsigned EVT_ACK = 1;
  localparam int unsigned EVT_ABT = 2;

  function automatic rx_mode_e decode_mode(input logic rx_en, input logic mr_en);
    if (!rx_en)     return RX_OFF;
    else if (mr_en) return RX_ALL;
    else            return RX_FIRST;
  endfunction
endpackage

// File: rtl/mon_rx_frame_track.sv
module mon_rx_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic mx_in,
  input  logic mr_ctrl_en,
  output logic new_byte,
  output logic first_byte,
  output logic end_evt
);
  logic mx_prev;
  logic pkt_open;
  logic mrc_q;
  logic mrc_drop;

  assign mrc_drop   = mrc_q & ~mr_ctrl_en;
  assign new_byte   = frame_tick & mx_prev & ~mx_in;
  assign first_byte = new_byte & ~pkt_open;
  assign end_evt    = frame_tick & pkt_open & mx_prev & mx_in & ~mrc_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mx_prev  <= 1'b1;
      pkt_open <= 1'b0;
      mrc_q    <= 1'b0;
    end else begin
      mrc_q <= mr_ctrl_en;
      if (frame_tick) mx_prev <= mx_in;
      if (mrc_drop)      pkt_open <= 1'b0;
      else if (new_byte) pkt_open <= 1'b1;
      else if (end_evt)  pkt_open <= 1'b0;
    end
  end
endmodule

// File: rtl/mon_rx_slot.sv
module mon_rx_slot
  import mon_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              mx_in,
  input  rx_mode_e          mode,
  input  logic              new_byte,
  input  logic              first_byte,
  input  logic [DATA_W-1:0] mon_byte,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              mr_out,
  output logic              ack_evt,
  output logic              abort_evt
);
  logic want_store;
  logic take;
  logic slot_free;
  logic mr_low;

  assign want_store = new_byte & ((mode == RX_ALL) | ((mode == RX_FIRST) & first_byte));
  assign take       = rx_valid & rx_ready;
  assign slot_free  = ~rx_valid | rx_ready;
  assign abort_evt  = want_store & ~slot_free;
  assign ack_evt    = take & (mode == RX_ALL);
  assign mr_out     = ~mr_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else if (want_store && slot_free) begin
      rx_data  <= mon_byte;
      rx_valid <= 1'b1;
    end else if (take) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mr_low <= 1'b0;
    else if (mode != RX_ALL)     mr_low <= 1'b0;
    else if (ack_evt)            mr_low <= 1'b1;
    else if (frame_tick && mx_in) mr_low <= 1'b0;
  end
endmodule

// File: rtl/mon_rx_flags.sv
module mon_rx_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  input  logic         evt_en,
  input  logic         rdy,
  output logic [N-1:0] sts,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sts[i] <= 1'b0;
      else if (evt[i]) sts[i] <= 1'b1;
      else if (clr)    sts[i] <= 1'b0;
    end
  end

  assign irq = rdy | (evt_en & (|sts));
endmodule

// File: rtl/mon_rx_handler.sv
module mon_rx_handler
  import mon_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              mx_in,
  input  logic [DATA_W-1:0] mon_byte,
  input  logic              rx_irq_en,
  input  logic              mr_ctrl_en,
  input  logic              evt_irq_en,
  input  logic              rx_ready,
  input  logic              stat_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              mr_out,
  output logic              sts_end,
  output logic              sts_ack,
  output logic              sts_abort,
  output logic              irq
);
  rx_mode_e         mode;
  logic             new_byte, first_byte, end_evt, ack_evt, abort_evt;
  logic [EVT_N-1:0] evt_vec, sts_vec;

  assign mode = decode_mode(rx_irq_en, mr_ctrl_en);

  mon_rx_frame_track u_track (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mx_in(mx_in),
    .mr_ctrl_en(mr_ctrl_en), .new_byte(new_byte), .first_byte(first_byte),
    .end_evt(end_evt)
  );

  mon_rx_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mx_in(mx_in),
    .mode(mode), .new_byte(new_byte), .first_byte(first_byte),
    .mon_byte(mon_byte), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_valid(rx_valid), .mr_out(mr_out), .ack_evt(ack_evt),
    .abort_evt(abort_evt)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[EVT_END] = end_evt;
    evt_vec[EVT_ACK] = ack_evt;
    evt_vec[EVT_ABT] = abort_evt;
  end

  mon_rx_flags #(.N(EVT_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(stat_clr),
    .evt_en(evt_irq_en), .rdy(rx_valid), .sts(sts_vec), .irq(irq)
  );

  assign sts_end   = sts_vec[EVT_END];
  assign sts_ack   = sts_vec[EVT_ACK];
  assign sts_abort = sts_vec[EVT_ABT];
endmodule

// File: rtl/mon_rx_handler_chk.sv
module mon_rx_handler_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              rx_irq_en,
  input logic              rx_ready,
  input logic              stat_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              mr_out,
  input logic              sts_end,
  input logic              sts_ack,
  input logic              sts_abort
);
  // R6
  hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R3
  off_mode_keeps_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq_en && !rx_valid) |=> !rx_valid);

  // R7
  mr_drop_on_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mr_out) |-> $past(rx_valid && rx_ready));

  // R9
  end_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_end) |-> $past(frame_tick));

  // R11
  clear_empties_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !frame_tick && !(rx_valid && rx_ready)) |=>
      (!sts_end && !sts_ack && !sts_abort));
endmodule

bind mon_rx_handler mon_rx_handler_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .rx_irq_en(rx_irq_en),
  .rx_ready(rx_ready), .stat_clr(stat_clr), .rx_data(rx_data),
  .rx_valid(rx_valid), .mr_out(mr_out), .sts_end(sts_end),
  .sts_ack(sts_ack), .sts_abort(sts_abort)
);

// File: tb/mon_rx_handler_tb_top.sv
module mon_rx_handler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0, mx_in = 1'b1;
  logic [7:0] mon_byte = '0;
  logic       rx_irq_en = 1'b0, mr_ctrl_en = 1'b0, evt_irq_en = 1'b0;
  logic       rx_ready = 1'b0, stat_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, mr_out, sts_end, sts_ack, sts_abort, irq;
  int         total = 0, bad = 0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mon_rx_handler dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mx_in(mx_in),
    .mon_byte(mon_byte), .rx_irq_en(rx_irq_en), .mr_ctrl_en(mr_ctrl_en),
    .evt_irq_en(evt_irq_en), .rx_ready(rx_ready), .stat_clr(stat_clr),
    .rx_data(rx_data), .rx_valid(rx_valid), .mr_out(mr_out),
    .sts_end(sts_end), .sts_ack(sts_ack), .sts_abort(sts_abort), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic frame(input logic mx, input logic [7:0] b);
    @(negedge clk);
    frame_tick = 1'b1; mx_in = mx; mon_byte = b;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 mr_out", mr_out, 1);
    chk("R1 flags", {sts_end, sts_ack, sts_abort}, 0);
    chk("R1 irq", irq, 0);

    // Sweep: mode m (0 off, 1 first-byte, 2 full) x packet length n
    for (int m = 0; m < 3; m++) begin
      for (int n = 1; n <= 3; n++) begin
        rx_irq_en  = (m != 0);
        mr_ctrl_en = (m == 2);
        evt_irq_en = n[0];
        frame(1'b1, 8'h00);
        frame(1'b1, 8'h00);
        clear_flags();
        chk("R11 cleared", {sts_end, sts_ack, sts_abort}, 0);
        for (int k = 0; k < n; k++) begin
          logic [7:0] val;
          int exp_v;
          val = 8'(m * 64 + n * 16 + k * 3 + 1);
          exp_v = ((m == 2) || (m == 1 && k == 0)) ? 1 : 0;
          frame(1'b0, val);
          // R3 R4 R5 mode selects which bytes are kept
          chk(m == 0 ? "R3 kept" : (m == 1 ? "R4 kept" : "R5 kept"), rx_valid, exp_v);
          if (exp_v == 1) chk("R2 data", rx_data, val);
          chk("R7 mr unread", mr_out, 1);
          chk("R12 irq byte", irq, exp_v | (n[0] & ((m == 2 && k > 0) ? 1 : 0)));
          if (exp_v == 1) begin
            repeat (3) @(negedge clk);
            chk("R6 held", rx_valid, 1);
            host_read();
            chk("R6 taken", rx_valid, 0);
            chk("R7 mr after read", mr_out, (m == 2) ? 0 : 1);
            chk("R8 ack flag", sts_ack, (m == 2) ? 1 : 0);
          end
          frame(1'b1, 8'h00);
          chk("R7 mr restored", mr_out, 1);
          chk("R9 single gap", sts_end, 0);
        end
        frame(1'b1, 8'h00);
        chk("R9 end", sts_end, 1);
        chk("R12 irq end", irq, n[0]);
      end
    end

    // R6 overrun: full mode, second byte while first unread
    rx_irq_en = 1'b1; mr_ctrl_en = 1'b1; evt_irq_en = 1'b1;
    clear_flags();
    frame(1'b0, 8'hA5);
    frame(1'b1, 8'h00);
    frame(1'b0, 8'h3C);
    chk("R6 abort flag", sts_abort, 1);
    chk("R6 held byte", rx_data, 8'hA5);
    chk("R6 still valid", rx_valid, 1);
    chk("R12 irq abort", irq, 1);
    host_read();
    chk("R6 drained", rx_valid, 0);
    frame(1'b1, 8'h00);
    // R11 end detected on same clock as clear: flag stays set
    @(negedge clk);
    frame_tick = 1'b1; mx_in = 1'b1; stat_clr = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0; stat_clr = 1'b0;
    chk("R11 set wins", sts_end, 1);
    chk("R11 others cleared", {sts_ack, sts_abort}, 0);

    // R10 MR control dropped mid-packet
    clear_flags();
    frame(1'b0, 8'h11);
    host_read();
    frame(1'b1, 8'h00);
    @(negedge clk); mr_ctrl_en = 1'b0;
    @(negedge clk);
    frame(1'b1, 8'h00);
    chk("R10 no end", sts_end, 0);
    frame(1'b0, 8'h22);
    chk("R10 new opening byte", rx_valid, 1);
    chk("R10 new data", rx_data, 8'h22);
    host_read();
    frame(1'b1, 8'h00);
    frame(1'b1, 8'h00);
    chk("R10 later end", sts_end, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule